// File: doc/BRIEF.md
# Inactivity-Driven Power Mode Controller

This block decides whether a sensor runs in its active mode, with a fast output data rate, or in its low-power mode, with a slow one. While the controller is active, an inactivity counter counts sample ticks down from a programmable limit. Every enabled interrupt event loads the limit into the counter again. When the counter runs out, the controller drops into low-power mode. In low-power mode, only events chosen by a wake-source mask bring it back to active mode.

The block drives the data-rate code the sampling logic should use. It also reports the current mode as a two-bit code and holds a sticky flag that records each mode change. The host clears the flag by reading the mode register, which the block sees as a one-cycle read strobe. When the feature is switched off, the controller sits in a standby state, drives the fast rate and never raises the flag.

Top module: `aslp_ctrl`

## Requirements
- R1: After reset, `mode` is 0, `trans_flag` is 0 and `odr_sel` equals `odr_wake`.
- R2: Whenever `en` was low at a clock edge, `mode` is 0 (standby) and `trans_flag` is 0 after that edge, whatever the events and strobes are.
- R3: With `en` high, standby moves to active mode (`mode` = 1) at the next edge, without setting `trans_flag`.
- R4: In active mode, any nonzero `evt` reloads the inactivity counter with `limit`. This holds even when a tick arrives in the same cycle.
- R5: In active mode with a nonzero `limit` L, and with no event since the last reload, the edge of the (L+1)-th tick puts `mode` at 2 (low-power).
- R6: A `limit` of 0 keeps the controller in active mode however many ticks arrive.
- R7: `odr_sel` equals `odr_sleep` while `mode` is 2, and equals `odr_wake` otherwise.
- R8: In low-power mode, `evt & wake_mask` being nonzero returns `mode` to 1 at the next edge. Events outside the mask leave the mode at 2.
- R9: Every change between active and low-power mode, in either direction, sets `trans_flag` at the same edge.
- R10: A `mode_rd` pulse clears `trans_flag` at the next edge. If a mode change happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Feature enable; low selects standby |
| tick | input | 1 | One-cycle pulse per sample period |
| evt | input | N_EVT | Enabled interrupt events, one per bit |
| wake_mask | input | N_EVT | Selects which events end low-power mode |
| limit | input | CNT_W | Inactivity limit in ticks; 0 disables sleep |
| odr_wake | input | ODR_W | Data-rate code used in active mode and standby |
| odr_sleep | input | ODR_W | Data-rate code used in low-power mode |
| mode_rd | input | 1 | Host read strobe of the mode register |
| mode | output | 2 | 0 standby, 1 active, 2 low-power |
| odr_sel | output | ODR_W | Data-rate code in force |
| trans_flag | output | 1 | Sticky mode-change flag |

## Verification
A directed run of ticks with no events checks that sleep begins exactly on the tick after the limit runs out. This separates an off-by-one counter from a correct one. The same run is then repeated with an event placed on a tick, which shows whether a reload wins over a decrement. Low-power mode is then hit with events outside the mask and then inside it, which tells the wake decoder apart from the plain activity OR. Read strobes are placed alone and on the same cycle as a mode change to expose the priority between setting and clearing the flag. Finally, several thousand cycles of seeded random ticks, events, masks, small limits, strobes and rare disables are compared cycle by cycle against a bench model.

// File: rtl/aslp_pkg.sv
package aslp_pkg;

    typedef enum logic [1:0] {
        MODE_STBY  = 2'd0,
        MODE_WAKE  = 2'd1,
        MODE_SLEEP = 2'd2
    } aslp_mode_e;

    typedef struct packed {
        aslp_mode_e mode;
        logic       flag;
    } aslp_fsm_st_t;

endpackage

// File: rtl/aslp_evt_reduce.sv
module aslp_evt_reduce #(
    parameter int N_EVT = 8
) (
    input  logic [N_EVT-1:0] evt,
    input  logic [N_EVT-1:0] wake_mask,
    output logic             any_evt,
    output logic             any_wake
);
    // OR chains built bit by bit so the width follows N_EVT
    logic [N_EVT:0] act_chain;
    logic [N_EVT:0] wake_chain;

    assign act_chain[0]  = 1'b0;
    assign wake_chain[0] = 1'b0;

    for (genvar i = 0; i < N_EVT; i++) begin : g_bit
        assign act_chain[i+1]  = act_chain[i]  | evt[i];
        assign wake_chain[i+1] = wake_chain[i] | (evt[i] & wake_mask[i]);
    end

    assign any_evt  = act_chain[N_EVT];
    assign any_wake = wake_chain[N_EVT];
endmodule

// File: rtl/aslp_inact_cnt.sv
module aslp_inact_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = limit;
        end else if (dec && (st_q.cnt != ZERO)) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = (st_q.cnt == ZERO);
endmodule

// File: rtl/aslp_mode_fsm.sv
module aslp_mode_fsm
    import aslp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       any_evt,
    input  logic       any_wake,
    input  logic       expired,
    input  logic       limit_zero,
    input  logic       rd,
    output aslp_mode_e mode,
    output logic       flag
);
    aslp_fsm_st_t st_d, st_q;
    logic         set_trans;

    always_comb begin
        st_d      = st_q;
        set_trans = 1'b0;
        if (!en) begin
            st_d.mode = MODE_STBY;
            st_d.flag = 1'b0;
        end else begin
            unique case (st_q.mode)
                MODE_STBY: st_d.mode = MODE_WAKE;
                MODE_WAKE: begin
                    if (tick && !any_evt && expired && !limit_zero) begin
                        st_d.mode = MODE_SLEEP;
                        set_trans = 1'b1;
                    end
                end
                MODE_SLEEP: begin
                    if (any_wake) begin
                        st_d.mode = MODE_WAKE;
                        set_trans = 1'b1;
                    end
                end
                default: st_d.mode = MODE_STBY;
            endcase
            // a new transition outranks a read in the same cycle
            st_d.flag = set_trans | (st_q.flag & ~rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_STBY, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;
    assign flag = st_q.flag;
endmodule

// File: rtl/aslp_ctrl.sv
module aslp_ctrl
    import aslp_pkg::*;
#(
    parameter int N_EVT = 8,
    parameter int CNT_W = 8,
    parameter int ODR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [N_EVT-1:0] evt,
    input  logic [N_EVT-1:0] wake_mask,
    input  logic [CNT_W-1:0] limit,
    input  logic [ODR_W-1:0] odr_wake,
    input  logic [ODR_W-1:0] odr_sleep,
    input  logic             mode_rd,
    output logic [1:0]       mode,
    output logic [ODR_W-1:0] odr_sel,
    output logic             trans_flag
);
    logic       any_evt;
    logic       any_wake;
    logic       expired;
    logic       cnt_load;
    logic       cnt_dec;
    aslp_mode_e cur_mode;

    aslp_evt_reduce #(.N_EVT(N_EVT)) u_reduce (
        .evt      (evt),
        .wake_mask(wake_mask),
        .any_evt  (any_evt),
        .any_wake (any_wake)
    );

    // outside active mode the counter tracks the limit so it is primed on wake
    assign cnt_load = (cur_mode != MODE_WAKE) | any_evt;
    assign cnt_dec  = tick & (cur_mode == MODE_WAKE);

    aslp_inact_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cnt_load),
        .dec    (cnt_dec),
        .limit  (limit),
        .expired(expired)
    );

    aslp_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .any_evt   (any_evt),
        .any_wake  (any_wake),
        .expired   (expired),
        .limit_zero(limit == '0),
        .rd        (mode_rd),
        .mode      (cur_mode),
        .flag      (trans_flag)
    );

    assign mode    = cur_mode;
    assign odr_sel = (cur_mode == MODE_SLEEP) ? odr_sleep : odr_wake;
endmodule

// File: rtl/aslp_ctrl_chk.sv
module aslp_ctrl_chk #(
    parameter int N_EVT = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [N_EVT-1:0] evt,
    input logic [N_EVT-1:0] wake_mask,
    input logic [CNT_W-1:0] limit,
    input logic             mode_rd,
    input logic [1:0]       mode,
    input logic             trans_flag
);
    a_r2_standby_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (mode == 2'd0) && !trans_flag);

    a_r3_standby_to_wake: assert property (@(posedge clk) disable iff (!rst_n)
        en && (mode == 2'd0) |=> (mode == 2'd1));

    a_r6_zero_limit_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) && (mode == 2'd1) |=> (mode != 2'd2));

    a_r8_masked_event_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        en && (mode == 2'd2) && ((evt & wake_mask) != '0) |=> (mode == 2'd1));

    a_r9_flag_on_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) && ($past(mode) == 2'd1) |-> trans_flag);

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        en && mode_rd && (mode == 2'd2) && ((evt & wake_mask) == '0) |=> !trans_flag);
endmodule

bind aslp_ctrl aslp_ctrl_chk #(.N_EVT(N_EVT), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .evt       (evt),
    .wake_mask (wake_mask),
    .limit     (limit),
    .mode_rd   (mode_rd),
    .mode      (mode),
    .trans_flag(trans_flag)
);

// File: tb/aslp_ctrl_tb_top.sv
module aslp_ctrl_tb_top;
    localparam int N_EVT = 8;
    localparam int CNT_W = 8;
    localparam int ODR_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             tick = 1'b0;
    logic [N_EVT-1:0] evt = '0;
    logic [N_EVT-1:0] wake_mask = '0;
    logic [CNT_W-1:0] limit = '0;
    logic [ODR_W-1:0] odr_wake = 3'd5;
    logic [ODR_W-1:0] odr_sleep = 3'd2;
    logic             mode_rd = 1'b0;
    logic [1:0]       mode;
    logic [ODR_W-1:0] odr_sel;
    logic             trans_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state
    int               m_mode = 0;
    logic [CNT_W-1:0] m_cnt = '0;
    bit               m_flag = 1'b0;

    always #10 clk = ~clk;

    aslp_ctrl #(.N_EVT(N_EVT), .CNT_W(CNT_W), .ODR_W(ODR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .evt(evt),
        .wake_mask(wake_mask), .limit(limit), .odr_wake(odr_wake),
        .odr_sleep(odr_sleep), .mode_rd(mode_rd), .mode(mode),
        .odr_sel(odr_sel), .trans_flag(trans_flag)
    );

    function automatic logic [ODR_W-1:0] exp_odr(int md);
        return (md == 2) ? odr_sleep : odr_wake;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one edge of the reference model, using the inputs present at that edge
    task automatic model_edge();
        bit set;
        set = 1'b0;
        if (!en) begin
            m_mode = 0; m_flag = 1'b0; m_cnt = limit;
        end else begin
            case (m_mode)
                0: begin m_mode = 1; m_cnt = limit; end
                1: begin
                    if (evt != '0) m_cnt = limit;
                    else if (tick) begin
                        if (m_cnt == '0 && limit != '0) begin m_mode = 2; set = 1'b1; end
                        else if (m_cnt != '0) m_cnt = m_cnt - 1'b1;
                    end
                end
                default: begin
                    if ((evt & wake_mask) != '0) begin m_mode = 1; set = 1'b1; end
                    m_cnt = limit;
                end
            endcase
            m_flag = set | (m_flag & ~mode_rd);
        end
    endtask

    task automatic compare_all();
        chk(mode == 2'(m_mode), "R5 R8 mode", int'(mode), m_mode);
        chk(trans_flag == m_flag, "R9 R10 trans_flag", int'(trans_flag), int'(m_flag));
        chk(odr_sel == exp_odr(m_mode), "R7 odr_sel", int'(odr_sel), int'(exp_odr(m_mode)));
    endtask

    task automatic cyc(bit t, logic [N_EVT-1:0] e, bit rd);
        tick = t; evt = e; mode_rd = rd;
        @(posedge clk);
        model_edge();
        #5;
        compare_all();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #5;
        // R1 reset state
        chk(mode == 2'd0, "R1 mode", int'(mode), 0);
        chk(trans_flag == 1'b0, "R1 trans_flag", int'(trans_flag), 0);
        chk(odr_sel == odr_wake, "R1 odr_sel", int'(odr_sel), int'(odr_wake));
        rst_n = 1'b1;

        // R2 disabled: events and reads change nothing
        en = 1'b0; limit = 8'd1; wake_mask = 8'hFF;
        for (int i = 0; i < 4; i++) cyc(1'b1, 8'hFF, 1'b1);
        chk(mode == 2'd0 && !trans_flag, "R2 standby", int'(mode), 0);

        // R3 enable moves to active mode without flag
        en = 1'b1; limit = 8'd3; wake_mask = 8'h01;
        cyc(1'b0, '0, 1'b0);
        chk(mode == 2'd1, "R3 mode", int'(mode), 1);
        chk(!trans_flag, "R3 flag", int'(trans_flag), 0);

        // R5 limit 3: three ticks stay active, the fourth enters sleep
        for (int i = 0; i < 3; i++) cyc(1'b1, '0, 1'b0);
        chk(mode == 2'd1, "R5 before expiry", int'(mode), 1);
        cyc(1'b1, '0, 1'b0);
        chk(mode == 2'd2, "R5 sleep entry", int'(mode), 2);
        chk(trans_flag, "R9 flag on sleep", int'(trans_flag), 1);
        chk(odr_sel == odr_sleep, "R7 sleep rate", int'(odr_sel), int'(odr_sleep));

        // R10 read clears
        cyc(1'b0, '0, 1'b1);
        chk(!trans_flag, "R10 cleared", int'(trans_flag), 0);

        // R8 unmasked event ignored, masked event wakes; read in same cycle loses
        cyc(1'b1, 8'h80, 1'b0);
        chk(mode == 2'd2, "R8 unmasked ignored", int'(mode), 2);
        cyc(1'b0, 8'h01, 1'b1);
        chk(mode == 2'd1, "R8 wake", int'(mode), 1);
        chk(trans_flag, "R10 set wins over read", int'(trans_flag), 1);
        cyc(1'b0, '0, 1'b1);

        // R4 event on a tick reloads
        limit = 8'd2;
        cyc(1'b0, 8'h40, 1'b0);
        cyc(1'b1, '0, 1'b0);
        cyc(1'b1, '0, 1'b0);
        cyc(1'b1, 8'h10, 1'b0);
        cyc(1'b1, '0, 1'b0);
        cyc(1'b1, '0, 1'b0);
        chk(mode == 2'd1, "R4 reload kept active", int'(mode), 1);
        cyc(1'b1, '0, 1'b0);
        chk(mode == 2'd2, "R4 sleep after reload", int'(mode), 2);

        // R6 limit zero never sleeps
        cyc(1'b0, 8'h01, 1'b1);
        limit = 8'd0;
        for (int i = 0; i < 20; i++) cyc(1'b1, '0, 1'b0);
        chk(mode == 2'd1, "R6 zero limit", int'(mode), 1);

        // R2 disable from active
        en = 1'b0;
        cyc(1'b1, 8'h01, 1'b0);
        chk(mode == 2'd0, "R2 disable", int'(mode), 0);

        // random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            if (i % 97 == 0) limit = CNT_W'($urandom_range(0, 5));
            if (i % 53 == 0) wake_mask = N_EVT'($urandom);
            en = ($urandom_range(0, 39) != 0);
            cyc($urandom_range(0, 1) == 1,
                ($urandom_range(0, 7) == 0) ? N_EVT'($urandom) : '0,
                $urandom_range(0, 5) == 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule